// File: doc/BRIEF.md
# Token-Bus Packet Frame Builder

This block turns a packet that host software has staged in one page of a local buffer RAM into the character stream of a token-passing link. It also produces the short control frames: a positive acknowledgement, a negative acknowledgement and a free-buffer enquiry. The buffer RAM holds eight pages of 256 bytes each. The block reads it through a synchronous read port that returns data one cycle after the request.

A job begins with a one-cycle start strobe. The strobe carries a frame-type select, a page number and, for enquiries, a destination ID. For a data frame the block first reads the four header bytes of the page. It then sends a start-of-header character, the source ID, the destination ID twice and the count field, followed by the information bytes. The count field tells short packets from long ones. A short packet stores 256 minus N in page byte 2. A long packet stores zero in byte 2 and 512 minus N in byte 3, and its data spans two consecutive pages. Information bytes are read from the offset named by the count up to the end of the packet region.

Each output byte is offered with a valid/ready handshake and carries a start-of-frame tag, which marks where the line coder places the preamble burst. Data bytes are prefetched, so the stream has no gaps while ready stays high. The block reports busy from the accepted strobe until the last byte is taken.

Top module: `frame_builder`

## Requirements
- R1: A start strobe is accepted only while busy is low. Busy is high from the cycle after an accepted strobe until the cycle after the final byte handshake. A strobe given while busy has no effect on the frame being sent and starts no further frame.
- R2: Frame type 00 sends a data frame whose first bytes are 01h, page byte 0 (source ID), page byte 1 (destination ID) and page byte 1 again.
- R3: When page byte 2 is nonzero, the count byte sent is the value of page byte 2. It is followed by the page bytes at offsets from that value up to 255, in ascending order.
- R4: When page byte 2 is 00h, 00h is sent and then page byte 3. The bytes that follow are at offsets from byte 3's value up to 511, counted from the page base. Addresses wrap modulo the 2048-byte buffer, so a long packet in page 7 continues in page 0.
- R5: Frame type 01 sends exactly one byte, 86h, and reads nothing from the RAM.
- R6: Frame type 10 sends exactly one byte, 15h.
- R7: Frame type 11 sends 85h and then twice the destination ID captured with the start strobe.
- R8: out_sof is high on the first byte of every frame and low on every other byte.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data and out_sof hold their values.
- R10: With out_ready held high, all bytes of a data frame leave on consecutive cycles with no gap.
- R11: After reset, busy, out_valid and ram_rd_en are low. The RAM is never read while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle job request |
| ftype | input | 2 | Frame type: 00 data, 01 ack, 10 nak, 11 enquiry |
| page | input | 3 | Buffer page of a data frame |
| dest_id | input | 8 | Destination ID for an enquiry |
| busy | output | 1 | Job in progress |
| ram_rd_en | output | 1 | RAM read request |
| ram_rd_addr | output | 11 | RAM byte address |
| ram_rd_data | input | 8 | RAM read data, one cycle after the request |
| out_data | output | 8 | Link character |
| out_valid | output | 1 | out_data is valid |
| out_sof | output | 1 | Character is the first of its frame |
| out_ready | input | 1 | Downstream accepts the character |

## Verification
The assertions check several properties on every cycle:
- output hold under back-pressure;
- busy persisting until the final handshake, and strobes while busy leaving the captured job untouched;
- the start-of-frame tag dropping after a non-final byte;
- the prefetch queue never overflowing or underflowing;
- RAM reads happening only during data jobs.

The byte contents can only be shown by the bench's scenarios, since it compares whole frames against frames it builds from its own copy of the RAM. Those scenarios cover short and long packets, the page-7 wrap, the three control codes, the latched enquiry ID and the exact cycle count of a gap-free frame.

// File: rtl/fb_pkg.sv
package fb_pkg;
   localparam int CHAR_W = 8;

   typedef enum logic [1:0] {
      FT_DATA = 2'd0,
      FT_ACK  = 2'd1,
      FT_NAK  = 2'd2,
      FT_ENQ  = 2'd3
   } ftype_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HDR   = 2'd1,
      ST_HWAIT = 2'd2,
      ST_EMIT  = 2'd3
   } seq_st_e;

   localparam logic [CHAR_W-1:0] CH_SOH  = 8'h01;
   localparam logic [CHAR_W-1:0] CH_ACK  = 8'h86;
   localparam logic [CHAR_W-1:0] CH_NAK  = 8'h15;
   localparam logic [CHAR_W-1:0] CH_ENQ  = 8'h85;
   localparam logic [CHAR_W-1:0] CH_LONG = 8'h00;

   // number of header bytes read from the page before emission
   localparam int HDR_READS = 4;
endpackage

// File: rtl/fb_hdr_capture.sv
module fb_hdr_capture
   import fb_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [SEL_W-1:0]  sel,
   input  logic [CHAR_W-1:0] rd_data,
   output logic              last_arrive,
   output logic [CHAR_W-1:0] sid,
   output logic [CHAR_W-1:0] did,
   output logic [CHAR_W-1:0] cnt,
   output logic [CHAR_W-1:0] cnt2
);
   localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(HDR_READS - 1);

   if (SEL_W < $clog2(HDR_READS)) begin : g_bad_sel
      $error("fb_hdr_capture: SEL_W too narrow for header reads");
   end

   logic             arr_v;
   logic [SEL_W-1:0] arr_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arr_v   <= 1'b0;
         arr_sel <= '0;
      end else begin
         arr_v   <= issue;
         arr_sel <= sel;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sid  <= '0;
         did  <= '0;
         cnt  <= '0;
         cnt2 <= '0;
      end else if (arr_v) begin
         case (arr_sel)
            SEL_W'(0): sid  <= rd_data;
            SEL_W'(1): did  <= rd_data;
            SEL_W'(2): cnt  <= rd_data;
            default:   cnt2 <= rd_data;
         endcase
      end
   end

   assign last_arrive = arr_v && (arr_sel == SEL_LAST);

   // R2: the final header byte arrives only right after another header byte
   p_hdr_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      last_arrive |-> $past(arr_v));
endmodule

// File: rtl/fb_prefetch_q.sv
module fb_prefetch_q
   import fb_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              issue,
   input  logic [CHAR_W-1:0] rd_data,
   input  logic              pop,
   output logic [CHAR_W-1:0] head,
   output logic              not_empty,
   output logic              can_issue
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = PTR_W + 1;
   localparam int SUM_W = CNT_W + 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("fb_prefetch_q: DEPTH must be at least 2");
   end
   if ((1 << PTR_W) != DEPTH) begin : g_bad_pow2
      $error("fb_prefetch_q: DEPTH must be a power of two");
   end

   logic                     inflight;
   logic [PTR_W-1:0]         wptr, rptr;
   logic [CNT_W-1:0]         count;
   logic [DEPTH*CHAR_W-1:0]  flat;
   logic                     wr;

   assign wr = inflight;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) inflight <= 1'b0;
      else               inflight <= issue;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [CHAR_W-1:0] ent_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                           ent_q <= '0;
         else if (wr && wptr == PTR_W'(i))     ent_q <= rd_data;
      end
      assign flat[i*CHAR_W +: CHAR_W] = ent_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (wr)  wptr <= wptr + 1'b1;
         if (pop) rptr <= rptr + 1'b1;
         case ({wr, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head      = flat[rptr*CHAR_W +: CHAR_W];
   assign not_empty = (count != '0);
   assign can_issue = (SUM_W'(count) + SUM_W'(inflight)) < SUM_W'(DEPTH);

   // R10: credit accounting keeps the queue within bounds
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !pop) |-> (count != CNT_W'(DEPTH)));
   p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));
endmodule

// File: rtl/fb_seq.sv
module fb_seq
   import fb_pkg::*;
#(
   parameter int PAGE_BYTES = 256,
   parameter int N_PAGES    = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   start,
   input  logic [1:0]                             ftype_in,
   input  logic [$clog2(N_PAGES)-1:0]             page_in,
   input  logic [CHAR_W-1:0]                      dest_in,
   output logic                                   hdr_issue,
   output logic [1:0]                             hdr_sel,
   input  logic                                   hdr_last,
   input  logic [CHAR_W-1:0]                      sid,
   input  logic [CHAR_W-1:0]                      did,
   input  logic [CHAR_W-1:0]                      cnt,
   input  logic [CHAR_W-1:0]                      cnt2,
   output logic                                   pf_issue,
   input  logic                                   pf_can_issue,
   input  logic [CHAR_W-1:0]                      pf_head,
   input  logic                                   pf_not_empty,
   output logic                                   pf_pop,
   output logic                                   q_clr,
   output logic [$clog2(N_PAGES*PAGE_BYTES)-1:0]  rd_addr,
   output logic [CHAR_W-1:0]                      out_data,
   output logic                                   out_valid,
   output logic                                   out_sof,
   input  logic                                   out_ready,
   output logic                                   busy
);
   localparam int OFF_W  = $clog2(PAGE_BYTES);
   localparam int PG_W   = $clog2(N_PAGES);
   localparam int ADDR_W = OFF_W + PG_W;
   localparam int IDX_W  = OFF_W + 2;

   if (PAGE_BYTES != (1 << CHAR_W)) begin : g_bad_page
      $error("fb_seq: page size must match the count character range");
   end
   if (N_PAGES < 2 || (1 << PG_W) != N_PAGES) begin : g_bad_pages
      $error("fb_seq: N_PAGES must be a power of two of at least 2");
   end

   seq_st_e             st;
   ftype_e              ft_q;
   logic [PG_W-1:0]     page_q;
   logic [CHAR_W-1:0]   dest_q;
   logic [1:0]          hsel;
   logic [IDX_W-1:0]    idx;
   logic [IDX_W-1:0]    rd_cnt;

   logic                is_data, is_long;
   logic [IDX_W-1:0]    n_hdr, n_data, total;
   logic [IDX_W-1:0]    data_first, data_end, off_sum;
   logic [CHAR_W-1:0]   hbyte;
   logic                in_hdr, fire, is_last;

   // ---------------- frame geometry ----------------
   always_comb begin
      is_data    = (ft_q == FT_DATA);
      is_long    = is_data && (cnt == CH_LONG);
      data_first = is_long ? IDX_W'(cnt2) : IDX_W'(cnt);
      data_end   = is_long ? IDX_W'(2*PAGE_BYTES - 1) : IDX_W'(PAGE_BYTES - 1);
      n_data     = is_data ? (data_end - data_first + IDX_W'(1)) : '0;
      case (ft_q)
         FT_DATA: n_hdr = is_long ? IDX_W'(6) : IDX_W'(5);
         FT_ENQ:  n_hdr = IDX_W'(3);
         default: n_hdr = IDX_W'(1);
      endcase
      total = n_hdr + n_data;
   end

   // ---------------- header character mux ----------------
   always_comb begin
      hbyte = '0;
      case (ft_q)
         FT_DATA: begin
            case (idx[2:0])
               3'd0:    hbyte = CH_SOH;
               3'd1:    hbyte = sid;
               3'd2:    hbyte = did;
               3'd3:    hbyte = did;
               3'd4:    hbyte = is_long ? CH_LONG : cnt;
               default: hbyte = cnt2;
            endcase
         end
         FT_ACK:  hbyte = CH_ACK;
         FT_NAK:  hbyte = CH_NAK;
         default: hbyte = (idx == '0) ? CH_ENQ : dest_q;
      endcase
   end

   // ---------------- output handshake ----------------
   assign in_hdr    = (idx < n_hdr);
   assign out_valid = (st == ST_EMIT) && (in_hdr || pf_not_empty);
   assign out_data  = in_hdr ? hbyte : pf_head;
   assign out_sof   = (st == ST_EMIT) && (idx == '0);
   assign fire      = out_valid && out_ready;
   assign is_last   = (idx == total - IDX_W'(1));
   assign pf_pop    = fire && !in_hdr;
   assign busy      = (st != ST_IDLE);
   assign q_clr     = (st == ST_IDLE);

   // ---------------- RAM requests ----------------
   assign hdr_issue = (st == ST_HDR);
   assign hdr_sel   = hsel;
   assign pf_issue  = (st == ST_EMIT) && is_data && (rd_cnt < n_data) && pf_can_issue;
   assign off_sum   = data_first + rd_cnt;

   always_comb begin
      if (hdr_issue)
         rd_addr = {page_q, OFF_W'(hsel)};
      else
         rd_addr = {page_q, {OFF_W{1'b0}}} + ADDR_W'(off_sum);
   end

   // ---------------- sequencer ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         ft_q   <= FT_DATA;
         page_q <= '0;
         dest_q <= '0;
         hsel   <= '0;
         idx    <= '0;
         rd_cnt <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start) begin
                  ft_q   <= ftype_e'(ftype_in);
                  page_q <= page_in;
                  dest_q <= dest_in;
                  hsel   <= '0;
                  idx    <= '0;
                  rd_cnt <= '0;
                  st     <= (ftype_e'(ftype_in) == FT_DATA) ? ST_HDR : ST_EMIT;
               end
            end
            ST_HDR: begin
               hsel <= hsel + 2'd1;
               if (hsel == 2'(HDR_READS - 1)) st <= ST_HWAIT;
            end
            ST_HWAIT: begin
               if (hdr_last) st <= ST_EMIT;
            end
            default: begin
               if (pf_issue) rd_cnt <= rd_cnt + IDX_W'(1);
               if (fire) begin
                  idx <= idx + IDX_W'(1);
                  if (is_last) st <= ST_IDLE;
               end
            end
         endcase
      end
   end

   // R1: busy persists until the final handshake
   p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(fire && is_last)) |=> busy);
   // R1: a strobe during a job leaves the captured job untouched
   p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(ft_q) && $stable(page_q) && $stable(dest_q)));
   // R9: a stalled character is held
   p_stall_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof)));
   // R8: the frame-start tag falls after a non-final accepted character
   p_sof_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !is_last) |=> !out_sof);
   // R5: control frames never touch the RAM
   p_ctrl_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ft_q != FT_DATA) |-> (!pf_issue && !hdr_issue));
endmodule

// File: rtl/frame_builder.sv
module frame_builder
   import fb_pkg::*;
#(
   parameter int PAGE_BYTES = 256,
   parameter int N_PAGES    = 8,
   parameter int PF_DEPTH   = 4,
   localparam int PG_W      = $clog2(N_PAGES),
   localparam int ADDR_W    = $clog2(N_PAGES*PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        ftype,
   input  logic [PG_W-1:0]   page,
   input  logic [7:0]        dest_id,
   output logic              busy,
   output logic              ram_rd_en,
   output logic [ADDR_W-1:0] ram_rd_addr,
   input  logic [7:0]        ram_rd_data,
   output logic [7:0]        out_data,
   output logic              out_valid,
   output logic              out_sof,
   input  logic              out_ready
);
   logic              hdr_issue, hdr_last;
   logic [1:0]        hdr_sel;
   logic [CHAR_W-1:0] sid, did, cnt, cnt2;
   logic              pf_issue, pf_can_issue, pf_not_empty, pf_pop, q_clr;
   logic [CHAR_W-1:0] pf_head;

   fb_seq #(
      .PAGE_BYTES (PAGE_BYTES),
      .N_PAGES    (N_PAGES)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .ftype_in     (ftype),
      .page_in      (page),
      .dest_in      (dest_id),
      .hdr_issue    (hdr_issue),
      .hdr_sel      (hdr_sel),
      .hdr_last     (hdr_last),
      .sid          (sid),
      .did          (did),
      .cnt          (cnt),
      .cnt2         (cnt2),
      .pf_issue     (pf_issue),
      .pf_can_issue (pf_can_issue),
      .pf_head      (pf_head),
      .pf_not_empty (pf_not_empty),
      .pf_pop       (pf_pop),
      .q_clr        (q_clr),
      .rd_addr      (ram_rd_addr),
      .out_data     (out_data),
      .out_valid    (out_valid),
      .out_sof      (out_sof),
      .out_ready    (out_ready),
      .busy         (busy)
   );

   fb_hdr_capture #(.SEL_W(2)) u_hdr (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue       (hdr_issue),
      .sel         (hdr_sel),
      .rd_data     (ram_rd_data),
      .last_arrive (hdr_last),
      .sid         (sid),
      .did         (did),
      .cnt         (cnt),
      .cnt2        (cnt2)
   );

   fb_prefetch_q #(.DEPTH(PF_DEPTH)) u_pfq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (q_clr),
      .issue     (pf_issue),
      .rd_data   (ram_rd_data),
      .pop       (pf_pop),
      .head      (pf_head),
      .not_empty (pf_not_empty),
      .can_issue (pf_can_issue)
   );

   assign ram_rd_en = hdr_issue || pf_issue;

   // R11: no RAM traffic outside a job
   p_rd_only_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ram_rd_en);
endmodule

// File: tb/tb_frame_builder.sv
module tb_frame_builder;
   localparam int MEMSZ = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  ftype = 2'd0;
   logic [2:0]  page = 3'd0;
   logic [7:0]  dest_id = 8'h00;
   logic        busy, ram_rd_en, out_valid, out_sof;
   logic        out_ready = 1'b1;
   logic [10:0] ram_rd_addr;
   logic [7:0]  ram_rd_data, out_data;

   logic [7:0]  mem [0:MEMSZ-1];
   logic [7:0]  exp_b [0:599];
   logic [7:0]  got_b [0:599];
   logic        got_s [0:599];
   int          got_c [0:599];
   int          exp_n, got_n, stall_bad;
   int          n_chk = 0, n_fail = 0, cyc = 0;

   always #4 clk = ~clk;

   frame_builder dut (
      .clk(clk), .rst_n(rst_n), .start(start), .ftype(ftype), .page(page),
      .dest_id(dest_id), .busy(busy), .ram_rd_en(ram_rd_en),
      .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
      .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof),
      .out_ready(out_ready)
   );

   always_ff @(posedge clk) if (ram_rd_en) ram_rd_data <= mem[ram_rd_addr];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic put_hdr(input int pg, input int s, input int d, input int c, input int c2);
      mem[pg*256+0] = 8'(s);
      mem[pg*256+1] = 8'(d);
      mem[pg*256+2] = 8'(c);
      mem[pg*256+3] = 8'(c2);
   endtask

   task automatic build_exp(input int ft, input int pg, input int dst);
      int base = pg*256;
      int first, last;
      exp_n = 0;
      case (ft)
         1: begin exp_b[0] = 8'h86; exp_n = 1; end
         2: begin exp_b[0] = 8'h15; exp_n = 1; end
         3: begin exp_b[0] = 8'h85; exp_b[1] = 8'(dst); exp_b[2] = 8'(dst); exp_n = 3; end
         default: begin
            exp_b[0] = 8'h01;
            exp_b[1] = mem[base];
            exp_b[2] = mem[base+1];
            exp_b[3] = mem[base+1];
            if (mem[base+2] != 8'h00) begin
               exp_b[4] = mem[base+2]; exp_n = 5;
               first = int'(mem[base+2]); last = 255;
            end else begin
               exp_b[4] = 8'h00; exp_b[5] = mem[base+3]; exp_n = 6;
               first = int'(mem[base+3]); last = 511;
            end
            for (int o = first; o <= last; o++) begin
               exp_b[exp_n] = mem[(base + o) % MEMSZ];
               exp_n++;
            end
         end
      endcase
   endtask

   task automatic kick(input int ft, input int pg, input int dst);
      @(negedge clk);
      start = 1'b1; ftype = 2'(ft); page = 3'(pg); dest_id = 8'(dst);
      @(negedge clk);
      start = 1'b0; dest_id = 8'hEE; ftype = 2'd2;
      check(busy == 1'b1, "R1", "busy after accepted start", busy, 1);
   endtask

   task automatic collect(input int mode, input int inj);
      bit prev_stall = 1'b0;
      logic [7:0] pd = 8'h00;
      logic ps = 1'b0;
      got_n = 0; stall_bad = 0;
      for (int it = 0; it < 3000; it++) begin
         if (it > 0) begin
            @(negedge clk);
            if (!busy) break;
         end
         out_ready = (mode == 0) ? 1'b1 : ((it % 3) != 1);
         if (it == inj) begin start = 1'b1; ftype = 2'd1; page = 3'd6; end
         else if (it == inj + 1) start = 1'b0;
         if (prev_stall && !(out_valid && out_data == pd && out_sof == ps)) stall_bad++;
         if (out_valid && out_ready && got_n < 600) begin
            got_b[got_n] = out_data; got_s[got_n] = out_sof; got_c[got_n] = it;
            got_n++;
         end
         prev_stall = out_valid && !out_ready;
         pd = out_data; ps = out_sof;
      end
      out_ready = 1'b1;
      start = 1'b0;
   endtask

   task automatic judge(input string req, input bit gapcheck);
      int bad = 0, first_bad = -1;
      int sof_bad = 0;
      for (int i = 0; i < got_n && i < exp_n; i++)
         if (got_b[i] !== exp_b[i]) begin
            bad++;
            if (first_bad < 0) first_bad = i;
         end
      if (first_bad >= 0)
         check(1'b0, req, $sformatf("byte %0d", first_bad),
               int'(got_b[first_bad]), int'(exp_b[first_bad]));
      else
         check(bad == 0 && got_n == exp_n, req, "frame length", got_n, exp_n);
      for (int i = 0; i < got_n; i++) if (got_s[i] != (i == 0)) sof_bad++;
      check(sof_bad == 0, "R8", "start-of-frame tags misplaced", sof_bad, 0);
      if (gapcheck)
         check(got_n > 0 && (got_c[got_n-1] - got_c[0]) == got_n - 1, "R10",
               "cycles spanned by frame", got_n > 0 ? got_c[got_n-1] - got_c[0] : -1,
               got_n - 1);
   endtask

   task automatic t_reset();
      check(busy == 1'b0, "R11", "busy after reset", busy, 0);
      check(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);
      check(ram_rd_en == 1'b0, "R11", "ram_rd_en after reset", ram_rd_en, 0);
   endtask

   task automatic t_short();
      put_hdr(2, 8'h21, 8'h4A, 8'hF0, 8'h33);
      build_exp(0, 2, 0);
      kick(0, 2, 0);
      collect(0, -1);
      judge("R2 R3 short 16 bytes", 1'b1);
   endtask

   task automatic t_short_bp();
      put_hdr(5, 8'h07, 8'hC3, 8'h04, 8'h99);
      build_exp(0, 5, 0);
      kick(0, 5, 0);
      collect(1, -1);
      judge("R3 short 252 bytes", 1'b0);
      check(stall_bad == 0, "R9", "stalled characters changed", stall_bad, 0);
   endtask

   task automatic t_long();
      put_hdr(1, 8'h55, 8'h12, 8'h00, 8'h80);
      build_exp(0, 1, 0);
      kick(0, 1, 0);
      collect(0, -1);
      judge("R4 long 384 bytes", 1'b1);
   endtask

   task automatic t_wrap();
      put_hdr(7, 8'hFE, 8'h01, 8'h00, 8'hF0);
      build_exp(0, 7, 0);
      kick(0, 7, 0);
      collect(1, -1);
      judge("R4 long wrap page 7", 1'b0);
      check(stall_bad == 0, "R9", "stalled characters changed", stall_bad, 0);
   endtask

   task automatic t_ack();
      build_exp(1, 0, 0);
      kick(1, 3, 8'h44);
      collect(0, -1);
      judge("R5 ack", 1'b1);
   endtask

   task automatic t_nak();
      build_exp(2, 0, 0);
      kick(2, 0, 8'h44);
      collect(1, -1);
      judge("R6 nak", 1'b0);
   endtask

   task automatic t_enq();
      build_exp(3, 0, 8'h3C);
      kick(3, 4, 8'h3C);
      collect(0, -1);
      judge("R7 enquiry", 1'b1);
   endtask

   task automatic t_ignore();
      int extra = 0;
      put_hdr(3, 8'h10, 8'h20, 8'hF8, 8'h00);
      build_exp(0, 3, 0);
      kick(0, 3, 0);
      collect(0, 3);
      judge("R1 start while busy ignored", 1'b1);
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (out_valid || busy) extra++;
      end
      check(extra == 0, "R1", "activity after ignored start", extra, 0);
   endtask

   initial begin
      for (int i = 0; i < MEMSZ; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 8));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_short();
      t_short_bp();
      t_long();
      t_wrap();
      t_ack();
      t_nak();
      t_enq();
      t_ignore();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule